// File: doc/BRIEF.md
# Eight-Source Interrupt Level Mapper

This block gathers eight level-sensitive interrupt request lines and folds them onto sixteen processor priority-level lines. A fixed, sparse table routes each request to one level. Requests 1, 2, 3, 4, 5 and 7 land on levels 1, 4, 6, 8, 10 and 14. Requests 0 and 6 are routed to level zero, which means they are discarded. Every routed request keeps a pending bit that simply follows its input. A level line is high while any pending request routed to it is present.

A single control byte sits behind a minimal register port: a select, a write strobe, write data and read data, with no address. Bit 6 of the byte cannot be stored. Bit 0 is a master gate: while it is clear, every level line is held low, but the pending bits keep tracking the inputs. All state is sampled on the rising clock edge, and the level lines are driven only from registered state. As a result, an input change or a control write is visible at the outputs right after the edge that captures it.

Top module: `irq_level_mapper`

## Requirements
- R1: Each routed request is level sensitive: its pending bit is set on an edge where its input is high and cleared on an edge where its input is low.
- R2: Requests 1, 2, 3, 4, 5 and 7 drive level lines 1, 4, 6, 8, 10 and 14 respectively (level line n is bit n of `lvl_out`).
- R3: Requests 0 and 6 never set a pending bit, and their inputs have no effect on any level line.
- R4: Bit n of `lvl_out` is high exactly when at least one pending request routed to level n is present and the gate is open; bit 0 is always low.
- R5: A stored control byte equals the write data ANDed with 0xBF, so bit 6 always reads as 0.
- R6: `cfg_rdata` always shows the stored control byte, combinationally and unchanged.
- R7: A synchronous active-low reset sets the control byte to 0x01, clears all pending bits and drives every level line low.
- R8: While control bit 0 is 0, all level lines are low while the pending bits keep following the inputs; setting bit 0 again shows the current pending state at once.
- R9: A change on a request input or a control write reaches the outputs after the next rising edge and not before it.
- R10: The control byte is written only on an edge where both `cfg_sel` and `cfg_we` are high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 8 | Level-sensitive interrupt requests |
| cfg_sel | input | 1 | Control register select |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Current control byte |
| lvl_out | output | 16 | Priority-level lines |

## Verification
The bench drives each request on its own and checks that only its own level line rises. A wrong table entry would light a neighbouring line, and a missing discard of requests 0 or 6 would raise line 0. It writes 0xFF and expects 0xBF back, so a missing mask would leave bit 6 set. It closes the gate while requests are active and changes them while the gate is closed. A design that froze the pending bits, or failed to gate, would then show stale or non-zero lines. It writes with only the select or only the strobe high, and it samples the outputs before the capturing edge. A design that wrote on a partial handshake, or let inputs pass straight through to the outputs, is caught there.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int SRC_N_DEF = 8;
  localparam int LVL_N_DEF = 16;
  localparam int CFG_W_DEF = 8;
  localparam int GATE_BIT  = 0;
  localparam int DEAD_BIT  = 6;

  // Fixed routing of a request index to a priority level; 0 means dropped.
  function automatic int src_level(input int s);
    case (s)
      1: return 1;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 10;
      7: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic bit src_used(input int s);
    return src_level(s) != 0;
  endfunction

  // Bits that a write may store: all except DEAD_BIT.
  function automatic logic [31:0] cfg_keep_mask(input int w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[i] = (i != DEAD_BIT);
    return m;
  endfunction

  // Value taken on reset: only the gate bit set.
  function automatic logic [31:0] cfg_reset_value();
    logic [31:0] v;
    v = '0;
    v[GATE_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irqmap_pkg::*;
#(
  parameter int SRC_N = SRC_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] irq_in,
  output logic [SRC_N-1:0] pend_q
);

  logic [SRC_N-1:0] live_req;

  // Only requests routed to a non-zero level may become pending.
  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    if (src_used(s)) begin : g_used
      assign live_req[s] = irq_in[s];
    end else begin : g_drop
      assign live_req[s] = 1'b0;
      // R3: a dropped request never holds a pending bit
      p_dropped_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[s] == 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= live_req;
  end

endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irqmap_pkg::*;
#(
  parameter int CFG_W = CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             wr_fire
);

  localparam logic [CFG_W-1:0] KEEP = CFG_W'(cfg_keep_mask(CFG_W));
  localparam logic [CFG_W-1:0] INIT = CFG_W'(cfg_reset_value());

  assign wr_fire = sel && we;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= INIT;
    else if (wr_fire) cfg_q <= wdata & KEEP;
  end

  // R5: the unusable bit never holds a one
  p_dead_bit_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[DEAD_BIT] == 1'b0);

  // R10: a full handshake stores the masked data
  p_write_lands_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we) |=> cfg_q == ($past(wdata) & KEEP));

  // R10: without a full handshake the byte holds
  p_write_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && we) |=> $stable(cfg_q));

endmodule

// File: rtl/irq_level_fold.sv
module irq_level_fold
  import irqmap_pkg::*;
#(
  parameter int SRC_N = SRC_N_DEF,
  parameter int LVL_N = LVL_N_DEF
) (
  input  logic [SRC_N-1:0] pend,
  input  logic             gate_open,
  output logic [LVL_N-1:0] lvl
);

  logic [LVL_N-1:0] raw_lvl;

  always_comb begin
    raw_lvl = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (pend[s] && src_used(s) && src_level(s) < LVL_N)
        raw_lvl[src_level(s)] = 1'b1;
    end
  end

  assign lvl = gate_open ? raw_lvl : '0;

endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irqmap_pkg::*;
#(
  parameter int SRC_N = SRC_N_DEF,
  parameter int LVL_N = LVL_N_DEF,
  parameter int CFG_W = CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] irq_in,
  input  logic             cfg_sel,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [LVL_N-1:0] lvl_out
);

  localparam logic [CFG_W-1:0] INIT = CFG_W'(cfg_reset_value());

  logic [SRC_N-1:0] pend_q;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_wr_fire;
  logic             gate_open;

  irq_pend_track #(.SRC_N(SRC_N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .pend_q (pend_q)
  );

  irq_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (cfg_sel),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q),
    .wr_fire (cfg_wr_fire)
  );

  assign gate_open = cfg_q[GATE_BIT];

  irq_level_fold #(.SRC_N(SRC_N), .LVL_N(LVL_N)) u_fold (
    .pend      (pend_q),
    .gate_open (gate_open),
    .lvl       (lvl_out)
  );

  assign cfg_rdata = cfg_q;

  // R7: first cycle out of reset shows the reset state
  p_reset_state_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rdata == INIT && lvl_out == '0));

  // R8: a closed gate silences every level line
  p_gate_closed_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[GATE_BIT] |-> lvl_out == '0);

  // R4: level zero is never driven
  p_level0_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    lvl_out[0] == 1'b0);

  // R1: an open gate with request 1 high lights level 1 on the next edge
  p_track_src1_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in[1] && gate_open && !cfg_wr_fire) |=> lvl_out[1]);

endmodule

// File: tb/irq_level_mapper_test.sv
module irq_level_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        cfg_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] lvl_out;

  int compared = 0;
  int mismatched = 0;
  int m_ctl = 1;
  int m_pend = 0;
  int lvl_of [8] = '{0, 1, 4, 6, 8, 10, 0, 14};
  string tag = "R7";

  always #2 clk = ~clk;

  irq_level_mapper uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_sel(cfg_sel),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lvl_out(lvl_out)
  );

  function automatic int exp_lvl();
    int v = 0;
    if ((m_ctl & 1) != 0)
      for (int s = 0; s < 8; s++)
        if (((m_pend >> s) & 1) != 0 && lvl_of[s] != 0) v |= (1 << lvl_of[s]);
    return v;
  endfunction

  task automatic check(input string t, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_ctl = 1;
      m_pend = 0;
    end else begin
      if (cfg_sel && cfg_we) m_ctl = int'(cfg_wdata) & 'hBF;
      m_pend = 0;
      for (int s = 0; s < 8; s++)
        if (irq_in[s] && lvl_of[s] != 0) m_pend |= (1 << s);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, int'(lvl_out), exp_lvl());
    check("R6", int'(cfg_rdata), m_ctl);
  endtask

  task automatic wr(input logic s, input logic w, input logic [7:0] d);
    cfg_sel = s; cfg_we = w; cfg_wdata = d;
    tick();
    cfg_sel = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R7: reset state
    tag = "R7";
    repeat (3) tick();
    check("R7", int'(cfg_rdata), 'h01);
    check("R7", int'(lvl_out), 0);
    rst_n = 1'b1;
    tick();

    // R2: each request alone
    tag = "R2";
    for (int s = 0; s < 8; s++) begin
      irq_in = 8'(1 << s);
      tick();
      check("R2", int'(lvl_out), (lvl_of[s] != 0) ? (1 << lvl_of[s]) : 0);
    end
    irq_in = '0; tick();

    // R3: dropped requests toggle with nothing else
    tag = "R3";
    for (int k = 0; k < 4; k++) begin
      irq_in = (k % 2 == 0) ? 8'h41 : 8'h01;
      tick();
      check("R3", int'(lvl_out), 0);
    end

    // R4 / R1: combined patterns and release
    tag = "R4";
    foreach (lvl_of[i]) begin end
    irq_in = 8'hFF; tick();
    check("R4", int'(lvl_out), 'h4552);
    irq_in = 8'hAA; tick();
    irq_in = 8'h55; tick();
    tag = "R1";
    irq_in = 8'h00; tick();
    check("R1", int'(lvl_out), 0);

    // R9: nothing moves before the capturing edge
    irq_in = 8'h80;
    #1;
    check("R9", int'(lvl_out), 0);
    tag = "R9"; tick();
    check("R9", int'(lvl_out), 'h4000);

    // R5: dead bit
    tag = "R5";
    wr(1'b1, 1'b1, 8'hFF);
    check("R5", int'(cfg_rdata), 'hBF);
    wr(1'b1, 1'b1, 8'h41);
    check("R5", int'(cfg_rdata), 'h01);

    // R8: closed gate, pending keeps tracking
    tag = "R8";
    irq_in = 8'h3E;
    wr(1'b1, 1'b1, 8'h00);
    check("R8", int'(lvl_out), 0);
    irq_in = 8'h04; tick();
    check("R8", int'(lvl_out), 0);
    wr(1'b1, 1'b1, 8'h01);
    check("R8", int'(lvl_out), 'h0010);

    // R10: partial handshakes
    tag = "R10";
    wr(1'b1, 1'b0, 8'h80);
    check("R10", int'(cfg_rdata), 'h01);
    wr(1'b0, 1'b1, 8'h80);
    check("R10", int'(cfg_rdata), 'h01);
    wr(1'b1, 1'b1, 8'h81);
    check("R10", int'(cfg_rdata), 'h81);

    // R7: reset in mid-run with requests held
    tag = "R7";
    irq_in = 8'hBE;
    rst_n = 1'b0; tick();
    check("R7", int'(cfg_rdata), 'h01);
    check("R7", int'(lvl_out), 0);
    rst_n = 1'b1; tick();
    tag = "R1";
    irq_in = 8'h00; tick();
    repeat (2) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule